// File: doc/BRIEF.md
# Edge-Aligned Single-to-Double Rate Clock Bridge

This block carries data words in both directions between a base clock and a clock of exactly twice its frequency. Both clocks come from one source, so they are synchronous, but their nominally coincident rising edges can be skewed against each other. The block does not use a dual-clock FIFO. A flop on the falling edge of the fast clock samples the level of the slow clock. That sample tells the fast domain, one half-cycle ahead, whether its next rising edge falls in the middle of a slow period. The result is a replica of the slow clock that acts as a clock enable in the fast domain.

Slow-domain words are taken into the fast domain only at the fast edge in mid slow period. They are never taken at the fast edge that coincides with a slow switching edge. Words going the other way are loaded only at that same mid-period edge. They are then held for two fast cycles, so the slow domain samples a value that has been steady for half a slow period on each side of its edge. After reset the enable stays low for a settling window of two fast cycles. Both valid outputs stay low during that window.

Top module: `dual_rate_bridge`

## Requirements
- R1: While rst_n is low, fast_valid and slow_valid are 0 at the next fast rising edge, and fast_ce is 0.
- R2: fast_ce stays 0 for the first two fast rising edges after rst_n goes high. Words offered on either side before the first enabled edge are dropped, and neither valid output rises for them.
- R3: Once settled, fast_ce is high in exactly every second fast cycle. It is high when the preceding fast falling edge sampled clk_slow high, which is the fast cycle whose closing rising edge lies mid slow period.
- R4: A word on up_data with up_valid=1, launched at a slow rising edge, appears on fast_data with fast_valid=1 from the first enabled fast edge after it. It lasts for exactly one fast cycle and within the same slow period.
- R5: A slow period with up_valid=0 produces no fast_valid pulse.
- R6: down_data and down_valid are sampled only at fast rising edges where fast_ce is high. Values present at the other fast edges have no effect on slow_data or slow_valid.
- R7: slow_data and slow_valid change only at enabled fast edges. A loaded word is therefore steady for two fast cycles, across exactly one slow rising edge.
- R8: Across long random traffic in both directions, every accepted word is delivered exactly once and in order: none is lost and none is duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Double-rate clock, source of all internal timing |
| clk_slow | input | 1 | Base-rate clock, sampled as data on fast falling edges |
| rst_n | input | 1 | Active-low reset, synchronous to clk_fast |
| up_data | input | W | Word from the slow domain |
| up_valid | input | 1 | Qualifies up_data for the current slow period |
| fast_data | output | W | Word delivered into the fast domain |
| fast_valid | output | 1 | One fast-cycle pulse per delivered word |
| fast_ce | output | 1 | Replica-phase clock enable for fast-domain logic |
| down_data | input | W | Word from the fast domain toward the slow domain |
| down_valid | input | 1 | Qualifies down_data at enabled edges |
| slow_data | output | W | Word held for the slow domain |
| slow_valid | output | 1 | Qualifies slow_data over one slow period |

## Verification
An upward word launched at a slow edge is due on fast_valid at the following mid-period fast edge, 7 ns after launch with the skew used here. The bench samples the output 13 ns after the launch and requires exactly that latency for every word. A downward word offered before an enabled edge is due at the slow edge 13 ns after loading. The bench reads it 1 ns after that slow edge and compares it with a second read taken before the edge. The enable itself is predicted from the bench's own clock model. It is checked every fast cycle, 2 ns after the fast falling edge that sets it. Offers made at non-enabled edges and in the settling window never enter the bench's expected queues, so any word that appears from them is counted as a failure.

// File: rtl/dr_bridge_pkg.sv
package dr_bridge_pkg;

  // Which register catches slow-domain data before the enabled fast edge
  typedef enum logic {
    CAP_RISE = 1'b0,  // straight into the rising-edge register at mid period
    CAP_FALL = 1'b1   // staged by a falling-edge register first (tighter path)
  } cap_style_e;

  // Saturating step of the post-reset settle counter
  function automatic int unsigned settle_next(input int unsigned cnt,
                                              input int unsigned limit);
    return (cnt >= limit) ? limit : cnt + 1;
  endfunction

  // An enabled fast edge needs the sampled slow level high and a settled tracker
  function automatic logic slot_open(input logic smp, input logic ok);
    return smp & ok;
  endfunction

endpackage

// File: rtl/dr_phase_track.sv
module dr_phase_track #(
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic clk_fast,
  input  logic clk_slow,
  input  logic rst_n,
  output logic settled,
  output logic fast_ce
);
  import dr_bridge_pkg::*;

  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);

  logic             phase_smp;
  logic [CNT_W-1:0] settle_cnt;

  // Falling-edge sample of the slow clock level: high means the next
  // fast rising edge lies in the middle of a slow period.
  always_ff @(negedge clk_fast) begin
    if (!rst_n) phase_smp <= 1'b0;
    else        phase_smp <= clk_slow;
  end

  always_ff @(posedge clk_fast) begin
    if (!rst_n) settle_cnt <= '0;
    else        settle_cnt <= CNT_W'(settle_next(32'(settle_cnt), SETTLE_CYC));
  end

  assign settled = (settle_cnt == CNT_W'(SETTLE_CYC));
  assign fast_ce = slot_open(phase_smp, settled);

  AST_CE_ALTERNATE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    fast_ce |=> !fast_ce);  // R3
  AST_CE_RETURNS: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (settled && !fast_ce) |=> fast_ce);  // R3
  AST_SETTLE_KEEPS: assert property (@(posedge clk_fast) disable iff (!rst_n)
    settled |=> settled);  // R2

endmodule

// File: rtl/dr_up_capture.sv
module dr_up_capture #(
  parameter int unsigned W = 16,
  parameter dr_bridge_pkg::cap_style_e STYLE = dr_bridge_pkg::CAP_RISE
) (
  input  logic         clk_fast,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] up_data,
  input  logic         up_valid,
  output logic [W-1:0] fast_data,
  output logic         fast_valid
);
  import dr_bridge_pkg::*;

  logic [W-1:0] src_data;
  logic         src_valid;

  generate
    if (STYLE == CAP_FALL) begin : g_fall
      logic [W-1:0] stg_data;
      logic         stg_valid;
      always_ff @(negedge clk_fast) begin
        if (!rst_n) begin
          stg_valid <= 1'b0;
          stg_data  <= '0;
        end else begin
          stg_valid <= up_valid;
          stg_data  <= up_data;
        end
      end
      assign src_data  = stg_data;
      assign src_valid = stg_valid;
    end else begin : g_rise
      assign src_data  = up_data;
      assign src_valid = up_valid;
    end
  endgenerate

  always_ff @(posedge clk_fast) begin
    if (!rst_n) begin
      fast_valid <= 1'b0;
      fast_data  <= '0;
    end else if (ce) begin
      fast_valid <= src_valid;
      fast_data  <= src_data;
    end else begin
      fast_valid <= 1'b0;
    end
  end

  AST_PULSE_ONE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    fast_valid |=> !fast_valid);  // R4
  AST_UP_IDLE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (ce && !src_valid) |=> !fast_valid);  // R5

endmodule

// File: rtl/dr_down_launch.sv
module dr_down_launch #(
  parameter int unsigned W = 16
) (
  input  logic         clk_fast,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] down_data,
  input  logic         down_valid,
  output logic [W-1:0] slow_data,
  output logic         slow_valid
);

  always_ff @(posedge clk_fast) begin
    if (!rst_n) begin
      slow_valid <= 1'b0;
      slow_data  <= '0;
    end else if (ce) begin
      slow_valid <= down_valid;
      slow_data  <= down_data;
    end
  end

  AST_LAUNCH_STABLE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !ce |=> $stable({slow_valid, slow_data}));  // R7
  AST_LAUNCH_TAKES: assert property (@(posedge clk_fast) disable iff (!rst_n)
    ce |=> (slow_valid == $past(down_valid)));  // R6

endmodule

// File: rtl/dual_rate_bridge.sv
module dual_rate_bridge #(
  parameter int unsigned W          = 16,
  parameter int unsigned SETTLE_CYC = 2,
  parameter dr_bridge_pkg::cap_style_e STYLE = dr_bridge_pkg::CAP_RISE
) (
  input  logic         clk_fast,
  input  logic         clk_slow,
  input  logic         rst_n,
  input  logic [W-1:0] up_data,
  input  logic         up_valid,
  output logic [W-1:0] fast_data,
  output logic         fast_valid,
  output logic         fast_ce,
  input  logic [W-1:0] down_data,
  input  logic         down_valid,
  output logic [W-1:0] slow_data,
  output logic         slow_valid
);

  logic settled;

  dr_phase_track #(.SETTLE_CYC(SETTLE_CYC)) u_track (
    .clk_fast (clk_fast),
    .clk_slow (clk_slow),
    .rst_n    (rst_n),
    .settled  (settled),
    .fast_ce  (fast_ce)
  );

  dr_up_capture #(.W(W), .STYLE(STYLE)) u_up (
    .clk_fast   (clk_fast),
    .rst_n      (rst_n),
    .ce         (fast_ce),
    .up_data    (up_data),
    .up_valid   (up_valid),
    .fast_data  (fast_data),
    .fast_valid (fast_valid)
  );

  dr_down_launch #(.W(W)) u_down (
    .clk_fast   (clk_fast),
    .rst_n      (rst_n),
    .ce         (fast_ce),
    .down_data  (down_data),
    .down_valid (down_valid),
    .slow_data  (slow_data),
    .slow_valid (slow_valid)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk_fast)
    !rst_n |=> (!fast_valid && !slow_valid));  // R1
  AST_QUIET_UNSETTLED: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !settled |-> (!fast_valid && !slow_valid && !fast_ce));  // R2

endmodule

// File: tb/sim_dual_rate_bridge.sv
module sim_dual_rate_bridge;
  localparam int W = 16;

  logic         clk_fast, clk_slow, rst_n;
  logic [W-1:0] up_data, fast_data, down_data, slow_data;
  logic         up_valid, fast_valid, fast_ce, down_valid, slow_valid;

  int checks = 0;
  int errors = 0;
  int mode   = 0;   // 0 random, 1 down only off-slot / up idle, 2 back-to-back, 9 stop
  bit finished = 0;

  logic [W-1:0] up_q[$];
  longint       up_t[$];
  logic [W-1:0] dn_q[$];
  longint       dn_t[$];

  dual_rate_bridge #(.W(W)) u0 (
    .clk_fast(clk_fast), .clk_slow(clk_slow), .rst_n(rst_n),
    .up_data(up_data), .up_valid(up_valid),
    .fast_data(fast_data), .fast_valid(fast_valid), .fast_ce(fast_ce),
    .down_data(down_data), .down_valid(down_valid),
    .slow_data(slow_data), .slow_valid(slow_valid)
  );

  // 100 MHz fast clock: rising edges at 10k ns
  initial begin
    clk_fast = 0; #10;
    forever begin clk_fast = 1; #5; clk_fast = 0; #5; end
  end
  // half-rate clock, rising 3 ns after every second fast rising edge (skew)
  initial begin
    clk_slow = 0; #3;
    forever begin clk_slow = 1; #10; clk_slow = 0; #10; end
  end

  function automatic bit ce_due(longint t);
    // enable high in [20k+5, 20k+15) once the edge at 120 ns has passed
    return (t >= 121) && ((t % 20) == 7);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", req, what, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // slow-side producer: drives 1 ns after each slow rising edge
  initial begin
    up_valid = 0; up_data = '0;
    forever begin
      @(posedge clk_slow); #1;
      if (mode == 9) begin up_valid = 0; end
      else begin
        up_data  = W'($urandom);
        up_valid = (mode == 1) ? 1'b0 : (mode == 2) ? 1'b1 : 1'($urandom % 3 != 0);
        if (up_valid && $time >= 124) begin up_q.push_back(up_data); up_t.push_back($time); end
      end
    end
  end

  // fast-side producer: drives 1 ns after each fast rising edge
  initial begin
    down_valid = 0; down_data = '0;
    forever begin
      @(posedge clk_fast); #1;
      if (mode == 9) down_valid = 0;
      else begin
        down_data = W'($urandom);
        if (mode == 1)      down_valid = (($time % 20) == 11);   // only non-enabled edges
        else if (mode == 2) down_valid = 1'b1;
        else                down_valid = 1'($urandom % 2);
        if (down_valid && ($time % 20) == 1 && $time >= 121) begin
          dn_q.push_back(down_data); dn_t.push_back($time);
        end
      end
    end
  end

  // fast-side monitor: 7 ns after each fast rising edge
  initial begin
    forever begin
      @(posedge clk_fast); #7;
      if (!rst_n) begin
        check(fast_ce == 0 && fast_valid == 0 && slow_valid == 0, "R1", "outputs in reset",
              {fast_ce, fast_valid, slow_valid}, 0);
      end else begin
        check(fast_ce == ce_due($time), ($time < 130) ? "R2" : "R3", "fast_ce phase",
              fast_ce, ce_due($time));
        if (fast_valid) begin
          if (up_q.size() == 0)
            check(0, ($time < 140) ? "R2" : "R5", "unexpected fast_valid", 1, 0);
          else begin
            logic [W-1:0] e; longint ts;
            e = up_q.pop_front(); ts = up_t.pop_front();
            check(fast_data == e, "R4", "fast_data", fast_data, e);
            check($time - ts == 13, "R4", "upward latency ns", $time - ts, 13);
          end
        end else if (up_q.size() != 0 && $time - up_t[0] >= 13) begin
          check(0, "R8", "upward word lost", 0, up_q[0]);
          void'(up_q.pop_front()); void'(up_t.pop_front());
        end
      end
    end
  end

  // slow-side consumer: 1 ns after each slow rising edge, plus a pre-edge read
  initial begin
    logic [W:0] pre;
    bit have_pre = 0;
    forever begin
      @(posedge clk_slow); #1;
      if (rst_n && have_pre)
        check({slow_valid, slow_data} == pre, "R7", "slow output held across slow edge",
              {slow_valid, slow_data}, pre);
      if (rst_n && slow_valid) begin
        if (dn_q.size() == 0)
          check(0, ($time < 150) ? "R2" : "R6", "unexpected slow_valid", 1, 0);
        else begin
          logic [W-1:0] e; longint ts;
          e = dn_q.pop_front(); ts = dn_t.pop_front();
          check(slow_data == e, "R6", "slow_data", slow_data, e);
          check($time - ts == 23, "R7", "downward latency ns", $time - ts, 23);
        end
      end else if (rst_n && dn_q.size() != 0 && $time - dn_t[0] >= 23) begin
        check(0, "R8", "downward word lost", 0, dn_q[0]);
        void'(dn_q.pop_front()); void'(dn_t.pop_front());
      end
      #12;
      pre = {slow_valid, slow_data};
      have_pre = rst_n;
    end
  end

  // watchdog
  initial begin
    #1_000_000;
    if (!finished) begin
      check(0, "R8", "watchdog expired", 0, 1);
      finish_run();
    end
  end

  // main sequence
  initial begin
    void'($urandom(32'd4242));
    rst_n = 0;
    #101 rst_n = 1;
    repeat (800) @(posedge clk_slow);
    mode = 1;                              // R5 / R6 directed window
    repeat (40) @(posedge clk_slow);
    mode = 2;                              // back-to-back both directions
    repeat (40) @(posedge clk_slow);
    mode = 0;
    repeat (300) @(posedge clk_slow);
    mode = 9;
    repeat (10) @(posedge clk_slow);
    #5;
    check(up_q.size() == 0, "R8", "upward queue drained", up_q.size(), 0);
    check(dn_q.size() == 0, "R8", "downward queue drained", dn_q.size(), 0);
    check(fast_valid == 0 && slow_valid == 0, "R5", "idle after stop",
          {fast_valid, slow_valid}, 0);
    finished = 1;
    finish_run();
  end

endmodule